// File: doc/BRIEF.md
# Reconfigurable Host Register Port

This block lets an external microprocessor read and write a bank of sixteen 8-bit registers inside a larger chip. Two static strap pins fix the bus at power-up. One picks a shared address/data bus, where an 8-bit byte carries the address first and then the data, or a split bus with a separate 4-bit address. The other picks between two strobe styles. In the first style an active-low address strobe, an active-low data strobe, a read/write level and an active-low acknowledge are used. In the second style an active-high address latch enable, separate active-low read and write strobes and an active-high ready are used.

The host bus is a strobe protocol, so it stays as plain pins and has no valid/ready pair. Back-pressure comes from the handshake pin. The host holds its data strobe until the acknowledge asserts, or until ready rises again. The block stretches every access by a fixed number of clock cycles set by a parameter. On the shared bus the upper nibble of the address byte is compared with a device-ID field held in register 4. Several copies of the block can then share one bus, and only the copy with the matching ID responds. All bus inputs are assumed to be synchronous to `clk`.

Top module: `mpi_bus_port`

## Requirements
- R1: The straps `{mode_ale, mode_mux}` select the mode. Bit `mode_ale`=0 is the strobe/read-write style: a read is `ds_rd_n`=0 with `rw_wr_n`=1, and a write is `ds_rd_n`=0 with `rw_wr_n`=0. Bit `mode_ale`=1 is the read/write-strobe style: `ds_rd_n`=0 is a read and `rw_wr_n`=0 is a write. Bit `mode_mux`=1 selects the shared bus.
- R2: The address register loads on every clock edge while the address strobe is active. The strobe is active when `astb`=0 with `mode_ale`=0, and when `astb`=1 with `mode_ale`=1. It loads from `ad_in` on the shared bus and from `{4'b0, addr}` on the split bus, and it holds while the strobe is inactive. The low nibble of the address register selects the register.
- R3: On the shared bus the block is selected only when `cs_n`=0 and address bits [7:4] equal bits [7:4] of register 4. A non-matching access drives nothing and writes nothing. On the split bus the ID is ignored.
- R4: Reset sets register 4 to `ID_RESET`. Writing register 4 changes the device ID.
- R5: A write stores `ad_in` in the addressed register exactly once per strobe. The store happens on the edge that completes the wait count. A later read returns the stored value.
- R6: `ad_oe` is 1 only while the block is selected and a read strobe is active, and `ad_out` then carries the addressed register.
- R7: The handshake completes `WAIT_CYCLES`+1 clock edges after the data strobe becomes active on a selected access. It stays complete until the strobe ends.
- R8: With `mode_ale`=0, `hs_out`=0 means acknowledge and `hs_out`=1 means not yet. With `mode_ale`=1, `hs_out`=0 means wait, and it is 0 from the start of the strobe until the handshake completes. At all other times `hs_out` is 1.
- R9: `hs_oe` is 1 only while the block is selected. Otherwise the handshake pin is released.
- R10: Strobes presented while `cs_n`=1 change no register and drive no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ale | input | 1 | Strap: 1 = read/write strobes with ready |
| mode_mux | input | 1 | Strap: 1 = shared address/data bus |
| cs_n | input | 1 | Active-low chip select |
| astb | input | 1 | Address strobe (active low) or address latch enable (active high) |
| ds_rd_n | input | 1 | Data strobe or read strobe, active low |
| rw_wr_n | input | 1 | Read/write level or write strobe |
| addr | input | AW | Split-bus address |
| ad_in | input | DW | Address/data bus, input side |
| ad_out | output | DW | Address/data bus, output side |
| ad_oe | output | 1 | Output enable for `ad_out` |
| hs_out | output | 1 | Acknowledge or ready level |
| hs_oe | output | 1 | Output enable for `hs_out` |

## Verification
The bench builds the block with its default 8-bit data and 4-bit address widths, `WAIT_CYCLES`=2 and `ID_RESET`=0x50. With these values every register can be written and read in all four modes, and every one of the sixteen possible ID nibbles can be swept on the shared bus. The nonzero wait count makes the stretched handshake visible on every access. The nonzero reset ID makes the reset value of register 4 distinguishable from an empty register.

// File: rtl/mpi_pkg.sv
package mpi_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT_DS  = 2'b00,
    MODE_SHARE_DS  = 2'b01,
    MODE_SPLIT_RW  = 2'b10,
    MODE_SHARE_RW  = 2'b11
  } bus_mode_e;

  typedef struct packed {
    logic astb;
    logic rd;
    logic wr;
  } bus_dec_t;
endpackage

// File: rtl/mpi_strobe_dec.sv
module mpi_strobe_dec
  import mpi_pkg::*;
(
  input  bus_mode_e mode,
  input  logic      astb,
  input  logic      ds_rd_n,
  input  logic      rw_wr_n,
  output bus_dec_t  dec
);
  logic rw_style;
  assign rw_style = mode[1];

  always_comb begin
    dec.astb = rw_style ? astb : ~astb;
    if (rw_style) begin
      dec.rd = ~ds_rd_n;
      dec.wr = ~rw_wr_n;
    end else begin
      dec.rd = ~ds_rd_n & rw_wr_n;
      dec.wr = ~ds_rd_n & ~rw_wr_n;
    end
  end
endmodule

// File: rtl/mpi_addr_latch.sv
module mpi_addr_latch #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int IDW = DW - AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shared,
  input  logic          cs_n,
  input  logic [DW-1:0] ad_in,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] id_reg,
  output logic [DW-1:0] adr_q,
  output logic          sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    adr_q <= '0;
    else if (load) adr_q <= shared ? ad_in : {{IDW{1'b0}}, addr};
  end

  logic id_match;
  generate
    if (IDW > 0) begin : g_id
      assign id_match = (adr_q[DW-1:AW] == id_reg[DW-1:AW]);
    end else begin : g_noid
      assign id_match = (id_reg == id_reg);
    end
  endgenerate

  assign sel = ~cs_n & (~shared | id_match);
endmodule

// File: rtl/mpi_regfile.sv
module mpi_regfile #(
  parameter int             DW       = 8,
  parameter int             AW       = 4,
  parameter int             ID_REG   = 4,
  parameter logic [DW-1:0]  ID_RESET = '0,
  localparam int            NREG     = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] id_reg
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mem[ID_REG] <= ID_RESET;
    else if (we) mem[idx] <= wdata;
  end

  assign rdata  = mem[idx];
  assign id_reg = mem[ID_REG];
endmodule

// File: rtl/mpi_handshake.sv
module mpi_handshake #(
  parameter int WAIT_CYCLES = 2,
  localparam int CW = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic rw_style,
  output logic done,
  output logic commit,
  output logic level
);
  logic [CW-1:0] cnt;
  logic          last;

  assign last   = (cnt == CW'(WAIT_CYCLES));
  assign commit = acc & ~done & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!acc) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (last) done <= 1'b1;
      else      cnt  <= cnt + 1'b1;
    end
  end

  assign level = rw_style ? ~(acc & ~done) : ~done;
endmodule

// File: rtl/mpi_bus_port.sv
module mpi_bus_port
  import mpi_pkg::*;
#(
  parameter int            DW          = 8,
  parameter int            AW          = 4,
  parameter int            WAIT_CYCLES = 2,
  parameter int            ID_REG      = 4,
  parameter logic [DW-1:0] ID_RESET    = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ale,
  input  logic          mode_mux,
  input  logic          cs_n,
  input  logic          astb,
  input  logic          ds_rd_n,
  input  logic          rw_wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          hs_out,
  output logic          hs_oe
);
  bus_mode_e     mode;
  bus_dec_t      dec;
  logic [DW-1:0] adr_q, id_reg, rdata;
  logic          sel, astb_act, rd_act, acc_act, acc_done, commit, level;

  assign mode = bus_mode_e'({mode_ale, mode_mux});

  mpi_strobe_dec u_dec (
    .mode(mode), .astb(astb), .ds_rd_n(ds_rd_n), .rw_wr_n(rw_wr_n), .dec(dec)
  );

  assign astb_act = dec.astb;
  assign rd_act   = dec.rd;

  mpi_addr_latch #(.DW(DW), .AW(AW)) u_adr (
    .clk(clk), .rst_n(rst_n), .load(astb_act), .shared(mode_mux), .cs_n(cs_n),
    .ad_in(ad_in), .addr(addr), .id_reg(id_reg), .adr_q(adr_q), .sel(sel)
  );

  assign acc_act = sel & (dec.rd | dec.wr);

  mpi_handshake #(.WAIT_CYCLES(WAIT_CYCLES)) u_hs (
    .clk(clk), .rst_n(rst_n), .acc(acc_act), .rw_style(mode_ale),
    .done(acc_done), .commit(commit), .level(level)
  );

  mpi_regfile #(.DW(DW), .AW(AW), .ID_REG(ID_REG), .ID_RESET(ID_RESET)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(commit & dec.wr), .idx(adr_q[AW-1:0]),
    .wdata(ad_in), .rdata(rdata), .id_reg(id_reg)
  );

  assign ad_out = rdata;
  assign ad_oe  = sel & dec.rd;
  assign hs_out = level;
  assign hs_oe  = sel;
endmodule

// File: rtl/mpi_bus_port_chk.sv
module mpi_bus_port_chk #(
  parameter int DW          = 8,
  parameter int WAIT_CYCLES = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_ale,
  input logic          cs_n,
  input logic          ad_oe,
  input logic          hs_oe,
  input logic          hs_out,
  input logic          rd_act,
  input logic          acc_act,
  input logic          acc_done,
  input logic          astb_act,
  input logic [DW-1:0] adr_q
);
  int cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cyc <= 0;
    else if (acc_act) cyc <= (cyc < WAIT_CYCLES + 8) ? cyc + 1 : cyc;
    else              cyc <= 0;
  end

  assert_ad_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!cs_n && rd_act));

  assert_hs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hs_oe |-> !cs_n);

  assert_ready_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ale && hs_oe && !hs_out) |-> (acc_act && !acc_done));

  assert_ack_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ale && hs_oe && !hs_out) |-> acc_done);

  assert_wait_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_done) |-> (cyc == WAIT_CYCLES + 1));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!astb_act && $past(!astb_act)) |-> $stable(adr_q));
endmodule

bind mpi_bus_port mpi_bus_port_chk #(.DW(DW), .WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_ale(mode_ale), .cs_n(cs_n), .ad_oe(ad_oe),
  .hs_oe(hs_oe), .hs_out(hs_out), .rd_act(rd_act), .acc_act(acc_act),
  .acc_done(acc_done), .astb_act(astb_act), .adr_q(adr_q)
);

// File: tb/sim_mpi_bus_port.sv
module sim_mpi_bus_port;
  localparam int         WAIT   = 2;
  localparam logic [7:0] ID_RST = 8'h50;
  localparam int         LIM    = WAIT + 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_ale = 1'b0, mode_mux = 1'b0, cs_n = 1'b1, astb = 1'b1;
  logic ds_rd_n = 1'b1, rw_wr_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] ad_in = '0, ad_out;
  logic ad_oe, hs_out, hs_oe;

  int checks = 0, errors = 0;
  logic [7:0] exp_mem [16];
  logic [3:0] cur_id;
  logic first_hs;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  mpi_bus_port #(.WAIT_CYCLES(WAIT), .ID_RESET(ID_RST)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_ale(mode_ale), .mode_mux(mode_mux), .cs_n(cs_n),
    .astb(astb), .ds_rd_n(ds_rd_n), .rw_wr_n(rw_wr_n), .addr(addr), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .hs_out(hs_out), .hs_oe(hs_oe)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_idle();
    cs_n = 1'b1; astb = mode_ale ? 1'b0 : 1'b1;
    ds_rd_n = 1'b1; rw_wr_n = 1'b1; ad_in = '0; addr = '0;
  endtask

  task automatic access(input bit rd, input logic [7:0] abyte, input logic [7:0] wd,
                        output logic [7:0] rdv, output int lat, output bit hs_seen,
                        output bit oe_seen, output bit ad_seen);
    @(negedge clk);
    cs_n = 1'b0; astb = mode_ale ? 1'b1 : 1'b0;
    if (mode_mux) ad_in = abyte;
    else begin addr = abyte[3:0]; ad_in = 8'hEE; end
    @(negedge clk);
    astb = mode_ale ? 1'b0 : 1'b1;
    ad_in = rd ? 8'h00 : wd;
    if (mode_ale) begin ds_rd_n = ~rd; rw_wr_n = rd; end
    else begin rw_wr_n = rd; ds_rd_n = 1'b0; end
    #1;
    first_hs = hs_out;
    lat = 0; hs_seen = 1'b0; oe_seen = hs_oe; ad_seen = ad_oe; rdv = '0;
    for (int k = 0; k < LIM && !hs_seen; k++) begin
      @(negedge clk); #1;
      lat++;
      oe_seen |= hs_oe; ad_seen |= ad_oe;
      if (hs_oe && (mode_ale ? hs_out : !hs_out)) begin
        hs_seen = 1'b1; rdv = ad_out;
      end
    end
    @(negedge clk);
    bus_idle();
    #1;
    chk(hs_oe == 1'b0, "R9", "hs_oe after release", hs_oe, 0);
    chk(ad_oe == 1'b0, "R6", "ad_oe after release", ad_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    int lat;
    bit hs, oe, ad;
    bus_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(hs_oe == 0 && ad_oe == 0, "R9", "idle outputs after reset", {hs_oe, ad_oe}, 0);
    cur_id = ID_RST[7:4];

    // R4: reset value of register 4, split bus strobe/read-write style
    access(1'b1, 8'h04, 8'h00, rv, lat, hs, oe, ad);
    chk(rv == ID_RST, "R4", "reset value of register 4", rv, ID_RST);

    for (int m = 0; m < 4; m++) begin
      mode_ale = m[1]; mode_mux = m[0];
      @(negedge clk); bus_idle();
      for (int i = 0; i < 16; i++) begin
        logic [7:0] v;
        v = 8'(i * 29 + m * 83 + 17);
        if (i == 4) v = {cur_id, v[3:0]};
        access(1'b0, {cur_id, 4'(i)}, v, rv, lat, hs, oe, ad);
        exp_mem[i] = v;
        chk(lat == WAIT + 1 && hs, "R7", "write handshake latency", lat, WAIT + 1);
        chk(first_hs == (mode_ale ? 1'b0 : 1'b1), "R8", "handshake level at strobe start",
            first_hs, mode_ale ? 0 : 1);
        chk(!ad, "R6", "ad_oe during write", ad, 0);
      end
      for (int i = 0; i < 16; i++) begin
        access(1'b1, {cur_id, 4'(i)}, 8'h00, rv, lat, hs, oe, ad);
        chk(rv == exp_mem[i], "R1", "readback per mode (R2 R5 address hold, stored data)", rv, exp_mem[i]);
        chk(ad && hs && lat == WAIT + 1, "R6", "read drives bus with handshake", {ad, hs}, 3);
      end
    end

    // R3: sweep all ID nibbles on the shared bus, both strobe styles
    for (int m = 1; m < 4; m += 2) begin
      mode_ale = m[1]; mode_mux = 1'b1;
      @(negedge clk); bus_idle();
      for (int n = 0; n < 16; n++) begin
        access(1'b1, {4'(n), 4'h2}, 8'h00, rv, lat, hs, oe, ad);
        if (4'(n) == cur_id)
          chk(hs && ad && rv == exp_mem[2], "R3", "matching ID responds", rv, exp_mem[2]);
        else
          chk(!hs && !oe && !ad, "R3", "foreign ID silent", {hs, oe, ad}, 0);
        if (4'(n) != cur_id) begin
          access(1'b0, {4'(n), 4'h2}, 8'hC3 ^ 8'(n), rv, lat, hs, oe, ad);
          chk(!oe, "R3", "foreign ID write not acknowledged", oe, 0);
        end
      end
      access(1'b1, {cur_id, 4'h2}, 8'h00, rv, lat, hs, oe, ad);
      chk(rv == exp_mem[2], "R3", "foreign writes ignored", rv, exp_mem[2]);
    end

    // R4: change the ID through the split bus, then address the new ID
    mode_ale = 1'b0; mode_mux = 1'b0;
    @(negedge clk); bus_idle();
    access(1'b0, 8'h04, 8'hA7, rv, lat, hs, oe, ad);
    cur_id = 4'hA; exp_mem[4] = 8'hA7;
    mode_mux = 1'b1;
    @(negedge clk); bus_idle();
    access(1'b1, 8'hA4, 8'h00, rv, lat, hs, oe, ad);
    chk(hs && rv == 8'hA7, "R4", "new ID selects device", rv, 8'hA7);
    access(1'b1, 8'h54, 8'h00, rv, lat, hs, oe, ad);
    chk(!oe, "R4", "old ID no longer selects", oe, 0);
    mode_mux = 1'b0;
    @(negedge clk); bus_idle();
    access(1'b1, 8'h07, 8'h00, rv, lat, hs, oe, ad);
    chk(hs && rv == exp_mem[7], "R3", "split bus ignores ID", rv, exp_mem[7]);

    // R10: strobes with chip select high
    for (int m = 0; m < 4; m++) begin
      mode_ale = m[1]; mode_mux = m[0];
      @(negedge clk); bus_idle();
      @(negedge clk);
      astb = mode_ale ? 1'b1 : 1'b0;
      ad_in = {cur_id, 4'h9}; addr = 4'h9;
      @(negedge clk);
      astb = mode_ale ? 1'b0 : 1'b1;
      ad_in = 8'h3C;
      if (mode_ale) rw_wr_n = 1'b0; else begin rw_wr_n = 1'b0; ds_rd_n = 1'b0; end
      repeat (WAIT + 3) begin
        @(negedge clk); #1;
        chk(!hs_oe && !ad_oe, "R10", "no drive with chip select high", {hs_oe, ad_oe}, 0);
      end
      @(negedge clk); bus_idle();
      access(1'b1, {cur_id, 4'h9}, 8'h00, rv, lat, hs, oe, ad);
      chk(rv == exp_mem[9], "R10", "register unchanged", rv, exp_mem[9]);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule